// File: doc/BRIEF.md
# Two-Bank Low-Power SDRAM Controller

This block sits between a simple single-word host request port and a two-bank, 16-bit low-power SDRAM holding 512K words per bank. After reset it runs the power-up sequence by itself: an idle wait with the clock enabled, a precharge of both banks, two refreshes, and a mode-register load. The mode register is set to sequential bursts, a CAS latency of 2 or 3, and single-word writes. From then on it accepts one host request at a time. It opens the addressed row and issues one READ or WRITE with auto-precharge, so every access leaves both banks closed.

A 20-bit host address is split as bank (bit 19), row (bits 18:8) and column (bits 7:0). A write moves one 16-bit word, and each of its two bytes can be enabled separately. A read returns a burst of `BURST_LEN` consecutive words on `rd_valid`/`rd_data`. A free-running refresh timer derived from the clock frequency raises a pending flag. That flag blocks new host requests, and the refresh goes out as soon as the access in progress has finished.

Top module: `lpsdr_ctrl`

## Requirements
- R1: While reset is high the command is NOP, `req_ready` is low and CKE is low. From the first clock after reset CKE stays high, and no command other than NOP is issued for at least `CLK_MHZ*INIT_US` cycles.
- R2: The commands `{cs_n,ras_n,cas_n,we_n}` are encoded as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000. The first four non-NOP commands are PRECHARGE with A10 high, then AUTO REFRESH `T_RP` cycles later, then AUTO REFRESH `T_RFC` cycles after that, then LOAD MODE `T_RFC` cycles after that. The first ACTIVE comes at least `T_MRD` cycles after LOAD MODE.
- R3: The LOAD MODE address word holds the burst-length code log2(`BURST_LEN`) in A2:0, 0 in A3 for the sequential type, the CAS latency in A6:4, and 1 in A9 for single-word writes. All other bits are 0.
- R4: Host bit 19 appears on A11 for both the ACTIVE and the following READ or WRITE. Host bits 18:8 appear on A10:0 at ACTIVE, and host bits 7:0 appear on A7:0 at READ or WRITE.
- R5: A READ or WRITE comes exactly `T_RCD` cycles after its ACTIVE.
- R6: Every READ and WRITE has A10 high. After a WRITE the next command is at least `T_WR+T_RP` cycles later. After a READ the next command is at least `CAS_LAT+BURST_LEN+T_RP` cycles later.
- R7: Each accepted write request issues exactly one WRITE. The host data is driven on the data bus in the WRITE cycle, and the controller drives the bus in no other cycle.
- R8: At WRITE, `sd_dqm[0]` (low byte) and `sd_dqm[1]` (high byte) are the inverse of `req_be[0]` and `req_be[1]`. At READ both masks are 0.
- R9: A READ accepted by the device at edge n returns `BURST_LEN` words on `rd_valid` in consecutive cycles. The first word is the one sampled at edge n+`CAS_LAT`. The words come in sequential order, wrapping inside the aligned burst.
- R10: AUTO REFRESH commands follow each other at most `CLK_MHZ*REFI_NS/1000 + T_RCD + CAS_LAT + BURST_LEN + T_RP + 2` cycles apart, even under back-to-back host requests. When a refresh is pending in idle, the refresh is issued before any host request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: bank, row, column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for the write |
| req_ready | output | 1 | Request accepted on this edge if valid |
| rd_valid | output | 1 | Read word present |
| rd_data | output | 16 | Read word |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Memory chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | A11 bank select, A10:0 row / column with auto-precharge |
| sd_dqm | output | 2 | Byte masks, bit 0 for the low byte |
| sd_dq | inout | 16 | Bidirectional memory data |

## Verification
A wrong state or timer value shows up on the command pins. The result is a command outside the initialisation order, or an ACTIVE-to-column spacing that differs from `T_RCD`. Either one is visible within a few cycles of the access that caused it. A wrong latched address or mask shows up on A11, the column bits or the byte masks of that same READ or WRITE. A read-capture pipeline that is off by one returns the wrong word, or the right word one cycle out of place, on the very first read. A broken refresh timer or a broken refresh priority does not show so soon. It only appears as a refresh gap longer than the stated bound, after a few thousand cycles.

// File: rtl/lpsdr_pkg.sv
`timescale 1ns/1ps
package lpsdr_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    S_WAIT, S_IPRE, S_IREF, S_IMRS, S_IDLE, S_RW
  } state_e;
endpackage

// File: rtl/lpsdr_refresh_timer.sv
`timescale 1ns/1ps
module lpsdr_refresh_timer #(
  parameter int PERIOD = 3120
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(PERIOD - 1);
      pend <= 1'b0;
    end else begin
      if (cnt == '0) cnt <= CW'(PERIOD - 1);
      else           cnt <= cnt - 1'b1;
      pend <= (cnt == '0) | (pend & ~ack);
    end
  end

  // R10: an acknowledged refresh clears the flag unless a new period just ended
  assert_pend_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && cnt != '0) |=> !pend);
endmodule

// File: rtl/lpsdr_read_capture.sv
`timescale 1ns/1ps
module lpsdr_read_capture #(
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 2,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int RW = $clog2(BURST_LEN + 1);
  logic [CAS_LAT-1:0] dl;
  logic [RW-1:0]      remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      dl       <= '0;
      remain   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      dl <= {dl[CAS_LAT-2:0], rd_issued};
      if (dl[CAS_LAT-1]) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
        remain   <= RW'(BURST_LEN - 1);
      end else if (remain != '0) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
        remain   <= remain - 1'b1;
      end else begin
        rd_valid <= 1'b0;
      end
    end
  end

  // R9: a new burst never starts while the previous one is still being collected
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    dl[CAS_LAT-1] |-> (remain == '0));
endmodule

// File: rtl/lpsdr_ctrl.sv
`timescale 1ns/1ps
module lpsdr_ctrl
  import lpsdr_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int INIT_US   = 100,
  parameter int REFI_NS   = 15600,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 12,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  localparam int HA_W     = 1 + ROW_W + COL_W,
  localparam int BYTES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [HA_W-1:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BYTES-1:0]  req_be,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W:0]    sd_addr,
  output logic [BYTES-1:0]  sd_dqm,
  inout  wire  [DATA_W-1:0] sd_dq
);
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int REFI_CYC = CLK_MHZ * REFI_NS / 1000;
  localparam int WR_GAP   = T_WR + T_RP;
  localparam int RD_GAP   = CAS_LAT + BURST_LEN + T_RP;
  localparam int BL_CODE  = $clog2(BURST_LEN);
  localparam int TMR_W    = $clog2(INIT_CYC + 1) + 1;
  localparam int AP_BIT   = ROW_W - 1;
  localparam logic [ROW_W:0] MODE_WORD =
    (ROW_W+1)'((1 << 9) | (CAS_LAT << 4) | BL_CODE);
  localparam logic [ROW_W:0] PRE_ALL = (ROW_W+1)'(1 << AP_BIT);

  state_e            st, ret;
  logic [TMR_W-1:0]  tmr;
  logic              second_ref;
  cmd_e              cmd_q;
  logic [ROW_W:0]    addr_q;
  logic [BYTES-1:0]  dqm_q;
  logic [DATA_W-1:0] dq_q;
  logic              dq_oe;
  logic              cke_q;
  logic              lat_write;
  logic [HA_W-1:0]   lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [BYTES-1:0]  lat_be;
  logic              ref_pend, ref_ack;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_cke    = cke_q;
  assign sd_dq     = dq_oe ? dq_q : 'z;
  assign req_ready = (st == S_IDLE) && !ref_pend;
  assign ref_ack   = (st == S_IDLE) && ref_pend;

  lpsdr_refresh_timer #(.PERIOD(REFI_CYC)) i_refresh (
    .clk(clk), .rst(rst), .ack(ref_ack), .pend(ref_pend)
  );

  lpsdr_read_capture #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .DATA_W(DATA_W)) i_capture (
    .clk(clk), .rst(rst), .rd_issued(cmd_q == CMD_RD), .dq_in(sd_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_WAIT;
      ret        <= S_IPRE;
      tmr        <= TMR_W'(INIT_CYC - 1);
      second_ref <= 1'b0;
      cmd_q      <= CMD_NOP;
      addr_q     <= '0;
      dqm_q      <= '1;
      dq_q       <= '0;
      dq_oe      <= 1'b0;
      cke_q      <= 1'b0;
      lat_write  <= 1'b0;
      lat_addr   <= '0;
      lat_data   <= '0;
      lat_be     <= '0;
    end else begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      dq_oe <= 1'b0;
      case (st)
        S_WAIT: begin
          if (tmr == '0) st <= ret;
          else           tmr <= tmr - 1'b1;
        end
        S_IPRE: begin
          cmd_q  <= CMD_PRE;
          addr_q <= PRE_ALL;
          tmr    <= TMR_W'(T_RP - 2);
          ret    <= S_IREF;
          st     <= S_WAIT;
        end
        S_IREF: begin
          cmd_q      <= CMD_REF;
          second_ref <= 1'b1;
          tmr        <= TMR_W'(T_RFC - 2);
          ret        <= second_ref ? S_IMRS : S_IREF;
          st         <= S_WAIT;
        end
        S_IMRS: begin
          cmd_q  <= CMD_LMR;
          addr_q <= MODE_WORD;
          tmr    <= TMR_W'(T_MRD - 2);
          ret    <= S_IDLE;
          st     <= S_WAIT;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_REF;
            tmr   <= TMR_W'(T_RFC - 2);
            ret   <= S_IDLE;
            st    <= S_WAIT;
          end else if (req_valid) begin
            cmd_q     <= CMD_ACT;
            addr_q    <= {req_addr[HA_W-1], req_addr[COL_W +: ROW_W]};
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_data  <= req_wdata;
            lat_be    <= req_be;
            tmr       <= TMR_W'(T_RCD - 2);
            ret       <= S_RW;
            st        <= S_WAIT;
          end
        end
        S_RW: begin
          addr_q <= {lat_addr[HA_W-1], 1'b1, {(ROW_W-1-COL_W){1'b0}}, lat_addr[COL_W-1:0]};
          if (lat_write) begin
            cmd_q <= CMD_WR;
            dq_q  <= lat_data;
            dq_oe <= 1'b1;
            dqm_q <= ~lat_be;
            tmr   <= TMR_W'(WR_GAP - 2);
          end else begin
            cmd_q <= CMD_RD;
            dqm_q <= '0;
            tmr   <= TMR_W'(RD_GAP - 2);
          end
          ret <= S_IDLE;
          st  <= S_WAIT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Cycles since the last ACTIVE, saturating; used only by the checks below
  logic [7:0] since_act;
  always_ff @(posedge clk) begin
    if (rst)                  since_act <= '0;
    else if (cmd_q == CMD_ACT) since_act <= 8'd1;
    else if (since_act != '1)  since_act <= since_act + 1'b1;
  end

  assert_cke_high_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sd_cke);
  assert_trcd_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (since_act == 8'(T_RCD)));
  assert_autopre_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_addr[AP_BIT]);
  assert_bus_drive_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe == (cmd_q == CMD_WR));
  assert_ref_first_R10: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && ref_pend) |=> (cmd_q == CMD_REF));
endmodule

// File: tb/test_lpsdr_ctrl.sv
`timescale 1ns/1ps
module test_lpsdr_ctrl;
  localparam int CLK_MHZ = 200, INIT_US = 2, REFI_NS = 15600;
  localparam int TRCD = 2, TRP = 3, TRFC = 12, TMRD = 2, TWR = 2, CL = 2, BL = 2;
  localparam int INIT_CYC = CLK_MHZ * INIT_US;
  localparam int REFI_CYC = CLK_MHZ * REFI_NS / 1000;
  localparam int WR_GAP = TWR + TRP, RD_GAP = CL + BL + TRP;
  localparam int REF_BOUND = REFI_CYC + TRCD + RD_GAP + 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [15:0] rd_data;
  logic [11:0] sd_addr;
  logic [1:0]  sd_dqm;
  wire  [15:0] sd_dq;
  logic        mdl_oe = 0;
  logic [15:0] mdl_dq = '0;
  assign sd_dq = mdl_oe ? mdl_dq : 'z;

  always #2.5 clk = ~clk;

  lpsdr_ctrl #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .REFI_NS(REFI_NS), .T_RCD(TRCD),
               .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_WR(TWR), .CAS_LAT(CL),
               .BURST_LEN(BL)) i_lpsdr_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq(sd_dq));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model and protocol monitor ----------------
  int cyc = 0, e0 = -1, nlog = 0;
  logic [3:0]  ilog_c [0:3];
  int          ilog_t [0:3];
  logic [11:0] ilog_a [0:3];
  int act_t = 0, rw_t = -1, rw_gap = 0, ref_t = -1, ref_cnt = 0, max_ref_gap = 0;
  int wr_cnt = 0, rd_t = 0, rdv_idx = 0, first_act_t = -1;
  bit lmr_seen = 0;
  logic act_bank;
  logic [10:0] act_row;
  logic [15:0] rg_d [0:15];
  bit          rg_v [0:15];
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [19:0] exp_addr = '0;
  logic [15:0] exp_data = '0;
  logic [1:0]  exp_be = '0;

  function automatic int key_of(input logic bank, input logic [10:0] row, input logic [7:0] col);
    return int'({bank, row, col});
  endfunction

  function automatic logic [7:0] wrap_col(input logic [7:0] col, input int b);
    logic [7:0] m = 8'(BL - 1);
    return (col & ~m) | (8'(int'(col) + b) & m);
  endfunction

  initial for (int i = 0; i < 16; i++) rg_v[i] = 0;

  always @(posedge clk) begin
    logic [3:0] c;
    logic [15:0] old;
    int k;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    cyc++;
    if (rst) begin
      mdl_oe <= 1'b0;
    end else begin
      if (e0 < 0) e0 = cyc;
      if (rd_valid) begin
        chk(cyc == rd_t + CL + 1 + rdv_idx, "R9 read word timing", cyc, rd_t + CL + 1 + rdv_idx);
        rdv_idx++;
      end
      if (c != C_NOP) begin
        if (nlog < 4) begin
          ilog_c[nlog] = c; ilog_t[nlog] = cyc; ilog_a[nlog] = sd_addr; nlog++;
        end
        if (rw_t >= 0) begin
          chk(cyc - rw_t >= rw_gap, "R6 spacing after access", cyc - rw_t, rw_gap);
          rw_t = -1;
        end
        case (c)
          C_LMR: lmr_seen = 1;
          C_ACT: begin
            if (first_act_t < 0) first_act_t = cyc;
            act_t = cyc; act_bank = sd_addr[11]; act_row = sd_addr[10:0];
            chk(sd_addr == {exp_addr[19], exp_addr[18:8]}, "R4 bank/row at ACTIVE",
                sd_addr, {exp_addr[19], exp_addr[18:8]});
          end
          C_RD, C_WR: begin
            chk(cyc - act_t == TRCD, "R5 ACTIVE to column command", cyc - act_t, TRCD);
            chk(sd_addr[11] == act_bank && sd_addr[7:0] == exp_addr[7:0],
                "R4 bank/column at access", {sd_addr[11], sd_addr[7:0]}, {exp_addr[19], exp_addr[7:0]});
            chk(sd_addr[10], "R6 auto-precharge A10", sd_addr[10], 1);
            rw_t = cyc;
            if (c == C_WR) begin
              rw_gap = WR_GAP;
              wr_cnt++;
              chk(sd_dq == exp_data, "R7 write data on bus", sd_dq, exp_data);
              chk(sd_dqm == ~exp_be, "R8 write byte masks", sd_dqm, ~exp_be);
              k = key_of(act_bank, act_row, sd_addr[7:0]);
              old = mem.exists(k) ? mem[k] : 16'h0;
              if (!sd_dqm[0]) old[7:0]  = sd_dq[7:0];
              if (!sd_dqm[1]) old[15:8] = sd_dq[15:8];
              mem[k] = old;
            end else begin
              rw_gap = RD_GAP;
              chk(sd_dqm == 2'b00, "R8 read masks low", sd_dqm, 0);
              rd_t = cyc; rdv_idx = 0;
              for (int b = 0; b < BL; b++) begin
                k = key_of(act_bank, act_row, wrap_col(sd_addr[7:0], b));
                rg_d[(cyc + CL - 1 + b) % 16] = mem.exists(k) ? mem[k] : 16'hDEAD;
                rg_v[(cyc + CL - 1 + b) % 16] = 1;
              end
            end
          end
          C_REF: if (lmr_seen) begin
            if (ref_t >= 0 && cyc - ref_t > max_ref_gap) max_ref_gap = cyc - ref_t;
            ref_t = cyc; ref_cnt++;
          end
          default: ;
        endcase
      end
      mdl_oe <= rg_v[cyc % 16];
      mdl_dq <= rg_d[cyc % 16];
      rg_v[cyc % 16] = 0;
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1;
    repeat (4) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 NOP in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(req_ready == 0, "R1 not ready in reset", req_ready, 0);
    chk(sd_cke == 0, "R1 CKE low in reset", sd_cke, 0);
    rst = 0;
    @(negedge clk);
    chk(sd_cke == 1, "R1 CKE high after reset", sd_cke, 1);
  endtask

  task automatic t_init();
    int t = 0;
    while (!req_ready && t < 2000) begin @(negedge clk); t++; end
    chk(req_ready == 1, "R2 ready after init", req_ready, 1);
    chk(nlog == 4, "R2 command count in init", nlog, 4);
    chk(ilog_t[0] - e0 >= INIT_CYC, "R1 initial NOP wait", ilog_t[0] - e0, INIT_CYC);
    chk(ilog_c[0] == C_PRE && ilog_a[0][10], "R2 first is PRECHARGE all", {ilog_c[0], ilog_a[0]}, {C_PRE, 12'h400});
    chk(ilog_c[1] == C_REF && ilog_t[1] - ilog_t[0] == TRP, "R2 refresh 1 after tRP",
        ilog_t[1] - ilog_t[0], TRP);
    chk(ilog_c[2] == C_REF && ilog_t[2] - ilog_t[1] == TRFC, "R2 refresh 2 after tRFC",
        ilog_t[2] - ilog_t[1], TRFC);
    chk(ilog_c[3] == C_LMR && ilog_t[3] - ilog_t[2] == TRFC, "R2 LOAD MODE after tRFC",
        ilog_t[3] - ilog_t[2], TRFC);
    chk(ilog_a[3] == 12'h221, "R3 mode word", ilog_a[3], 12'h221);
  endtask

  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    exp_addr = a; exp_data = d; exp_be = be;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    int w0 = wr_cnt;
    logic [15:0] old;
    int k = int'(a);
    issue(1, a, d, be);
    repeat (10) @(negedge clk);
    chk(wr_cnt - w0 == 1, "R7 one WRITE per request", wr_cnt - w0, 1);
    old = shadow.exists(k) ? shadow[k] : 16'h0;
    if (be[0]) old[7:0]  = d[7:0];
    if (be[1]) old[15:8] = d[15:8];
    shadow[k] = old;
  endtask

  task automatic do_read(input logic [19:0] a);
    int t = 0;
    issue(0, a, 16'h0, 2'b00);
    while (!rd_valid && t < 40) begin @(negedge clk); t++; end
    for (int b = 0; b < BL; b++) begin
      logic [19:0] wa = {a[19:8], wrap_col(a[7:0], b)};
      logic [15:0] e = shadow.exists(int'(wa)) ? shadow[int'(wa)] : 16'hDEAD;
      chk(rd_valid == 1, "R9 burst word valid", rd_valid, 1);
      chk(rd_data == e, "R9 burst word data", rd_data, e);
      @(negedge clk);
    end
    chk(rd_valid == 0, "R9 burst length", rd_valid, 0);
  endtask

  task automatic t_rw_patterns();
    do_write(20'h0_12_40, 16'hA5A5, 2'b11);   // bank 0
    do_write(20'h0_12_41, 16'h5A5A, 2'b11);
    do_read (20'h0_12_40);
    do_read (20'h0_12_41);                    // R9 wrap: 41 then 40
    do_write(20'h8_7F_F0, 16'h1234, 2'b11);   // bank 1
    do_write(20'h8_7F_F1, 16'hBEEF, 2'b11);
    do_read (20'h8_7F_F1);
  endtask

  task automatic t_byte_masks();
    do_write(20'h3_00_10, 16'h1111, 2'b11);
    do_write(20'h3_00_11, 16'h2222, 2'b11);
    do_write(20'h3_00_10, 16'hCC99, 2'b01);   // R8 low byte only
    do_write(20'h3_00_11, 16'h77EE, 2'b10);   // R8 high byte only
    do_read (20'h3_00_10);
  endtask

  task automatic t_refresh_idle();
    int r0 = ref_cnt;
    max_ref_gap = 0;
    repeat (7000) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R10 refreshes while idle", ref_cnt - r0, 2);
    chk(max_ref_gap > 0 && max_ref_gap <= REF_BOUND, "R10 idle refresh gap", max_ref_gap, REF_BOUND);
  endtask

  task automatic t_refresh_busy();
    int r0 = ref_cnt;
    max_ref_gap = 0;
    for (int i = 0; i < 640; i++) do_read(i[0] ? 20'h8_7F_F0 : 20'h0_12_40);
    chk(ref_cnt - r0 >= 2, "R10 refreshes under load", ref_cnt - r0, 2);
    chk(max_ref_gap > 0 && max_ref_gap <= REF_BOUND, "R10 busy refresh gap", max_ref_gap, REF_BOUND);
  endtask

  initial begin
    t_reset();
    t_init();
    chk(1, "R2 first ACTIVE spacing pending", 0, 0);
    t_rw_patterns();
    chk(first_act_t - ilog_t[3] >= TMRD, "R2 first ACTIVE after tMRD", first_act_t - ilog_t[3], TMRD);
    t_byte_masks();
    t_refresh_idle();
    t_refresh_busy();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule